// File: doc/BRIEF.md
# Flash Page Operation Sequencer

This block carries out page-level commands against a behavioural model of a flash main array. It holds two page-sized SRAM staging buffers. A command arrives as a single-cycle start pulse that carries an operation code, a page address and a buffer select. The sequencer then runs a fixed chain of self-timed phases. Each phase is a page-to-buffer transfer, a page erase or a buffer-to-page program. The busy flag stays high until the whole chain is done, and the status logic uses it as the ready/busy bit.

Each phase lasts exactly as many clock cycles as its parameter gives. These counts stand in for the transfer time (about 120 µs) and the erase-plus-program time (a few ms) of a real part. The byte copy or fill for a phase takes one byte per cycle at the start of the window. For the rest of the window the sequencer only waits. The full configuration is 4096 pages of 528 bytes with a 12-bit page address. The default parameters build a small array so that the block elaborates quickly. A block is a group of eight pages, and it is addressed by the page address with its low three bits dropped.

A host port writes and reads both buffers. A second read port shows the array contents. These ports are how the neighbouring logic loads buffer data and reads pages back.

Top module: `flash_page_seq`

## Requirements
- R1: While rst_n is low, and after it rises, busy_o=0, ready_o=1 and err_o=0. Asserting rst_n aborts any running sequence. The block does not resume that sequence, and an aborted transfer phase leaves the array unchanged.
- R2: Operation code 0 (program) writes the selected buffer into the addressed page. busy_o is high for exactly T_ERASE+T_PROG cycles, starting in the cycle after the start pulse is accepted.
- R3: For codes 0 and 1, the erase runs before the program. When the erase window has ended and before the program writes its first byte, every byte of the target page reads FFh.
- R4: Operation code 1 (rewrite) copies the addressed page into the selected buffer and then programs it back, so the page keeps its contents. busy_o is high for exactly T_XFER+T_ERASE+T_PROG cycles.
- R5: Operation code 2 (page erase) sets all bytes of the addressed page to FFh and holds busy_o for exactly T_ERASE cycles. No other page changes.
- R6: Operation code 3 (block erase) sets all PAGES_PER_BLOCK pages of the block selected by the upper page-address bits to FFh. The low page-address bits are ignored, busy_o lasts T_ERASE cycles, and pages outside the block are unchanged.
- R7: ready_o is the inverse of busy_o. A phase advances only when its down-counter reaches zero, so each phase lasts exactly its parameter count.
- R8: A start pulse that arrives while busy is dropped, and the running command continues with the same duration and result. err_o goes high and stays high until reset.
- R9: While busy, a host write to the buffer in use is dropped. A host write to the other buffer takes effect.
- R10: Buffer select 0 or 1 chooses the buffer used by codes 0 and 1. The other buffer is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, aborts any sequence |
| start_i | input | 1 | One-cycle command request |
| cmd_i | input | 2 | Operation: 0 program, 1 rewrite, 2 page erase, 3 block erase |
| page_i | input | PAW | Target page address |
| bufsel_i | input | 1 | Buffer used by program or rewrite |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | Inverse of busy, status ready bit |
| err_o | output | 1 | Sticky: a start arrived while busy |
| hw_en_i | input | 1 | Host buffer write enable |
| hw_sel_i | input | 1 | Host write buffer select |
| hw_addr_i | input | BAW | Host write byte address |
| hw_data_i | input | 8 | Host write data |
| hr_sel_i | input | 1 | Host read buffer select |
| hr_addr_i | input | BAW | Host read byte address |
| hr_data_o | output | 8 | Host read data |
| ar_page_i | input | PAW | Array read page |
| ar_byte_i | input | BAW | Array read byte |
| ar_data_o | output | 8 | Array read data |

## Verification
The array is first set to a known state with block erases whose low page bits are random. Random sequences of the four operations then run on random pages and buffers, with random buffer refills. A bench model predicts the whole array and both buffers after each command, and a mix-up of page, buffer or operation shows as a byte miscompare. Directed runs cover the remaining cases:
- reprogramming a page that holds non-FF data, sampled at the end of the erase window, which separates erase-then-program from a plain overwrite;
- a rewrite after the buffer has been loaded with different data, which shows whether the transfer really ran;
- a start pulse and host buffer writes injected in the middle of a sequence;
- a reset during a transfer.

// File: rtl/fps_pkg.sv
package fps_pkg;
   typedef enum logic [1:0] {
      OP_PROGRAM   = 2'd0,
      OP_REWRITE   = 2'd1,
      OP_PG_ERASE  = 2'd2,
      OP_BLK_ERASE = 2'd3
   } op_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_XFER  = 2'd1,
      PH_ERASE = 2'd2,
      PH_PROG  = 2'd3
   } phase_e;

   localparam logic [7:0] ERASED_BYTE = 8'hFF;
   localparam int         N_BUFS      = 2;
endpackage

// File: rtl/fps_phase_timer.sv
module fps_phase_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   input  logic          run_i,
   output logic          zero_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (load_i)                 cnt_q <= load_val_i;
      else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fps_page_buffer.sv
module fps_page_buffer #(
   parameter int PAGE_BYTES = 12,
   localparam int BAW = $clog2(PAGE_BYTES)
) (
   input  logic           clk,
   input  logic           we_i,
   input  logic [BAW-1:0] waddr_i,
   input  logic [7:0]     wdata_i,
   input  logic [BAW-1:0] raddr_a_i,
   output logic [7:0]     rdata_a_o,
   input  logic [BAW-1:0] raddr_b_i,
   output logic [7:0]     rdata_b_o
);
   logic [7:0] mem [PAGE_BYTES];

   always_ff @(posedge clk) begin
      if (we_i && 32'(waddr_i) < PAGE_BYTES) mem[waddr_i] <= wdata_i;
   end

   assign rdata_a_o = (32'(raddr_a_i) < PAGE_BYTES) ? mem[raddr_a_i] : 8'h00;
   assign rdata_b_o = (32'(raddr_b_i) < PAGE_BYTES) ? mem[raddr_b_i] : 8'h00;
endmodule

// File: rtl/fps_flash_array.sv
module fps_flash_array #(
   parameter int N_PAGES    = 32,
   parameter int PAGE_BYTES = 12,
   localparam int PAW   = $clog2(N_PAGES),
   localparam int BAW   = $clog2(PAGE_BYTES),
   localparam int DEPTH = N_PAGES * PAGE_BYTES,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we_i,
   input  logic [PAW-1:0] wpage_i,
   input  logic [BAW-1:0] wbyte_i,
   input  logic [7:0]     wdata_i,
   input  logic [PAW-1:0] rpage_a_i,
   input  logic [BAW-1:0] rbyte_a_i,
   output logic [7:0]     rdata_a_o,
   input  logic [PAW-1:0] rpage_b_i,
   input  logic [BAW-1:0] rbyte_b_i,
   output logic [7:0]     rdata_b_o
);
   logic [7:0] mem [DEPTH];

   function automatic logic [AW:0] lin(input logic [PAW-1:0] p, input logic [BAW-1:0] b);
      return (AW+1)'(p) * (AW+1)'(PAGE_BYTES) + (AW+1)'(b);
   endfunction

   function automatic logic in_range(input logic [BAW-1:0] b, input logic [AW:0] a);
      return (32'(b) < PAGE_BYTES) && (a < (AW+1)'(DEPTH));
   endfunction

   logic [AW:0] wa, ra, rb;
   assign wa = lin(wpage_i, wbyte_i);
   assign ra = lin(rpage_a_i, rbyte_a_i);
   assign rb = lin(rpage_b_i, rbyte_b_i);

   always_ff @(posedge clk) begin
      if (we_i && in_range(wbyte_i, wa)) mem[wa[AW-1:0]] <= wdata_i;
   end

   assign rdata_a_o = in_range(rbyte_a_i, ra) ? mem[ra[AW-1:0]] : 8'h00;
   assign rdata_b_o = in_range(rbyte_b_i, rb) ? mem[rb[AW-1:0]] : 8'h00;

   // R5
   wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |-> (32'(wbyte_i) < PAGE_BYTES && 32'(wpage_i) < N_PAGES));
endmodule

// File: rtl/fps_sequencer.sv
module fps_sequencer
   import fps_pkg::*;
#(
   parameter int N_PAGES         = 32,
   parameter int PAGE_BYTES      = 12,
   parameter int PAGES_PER_BLOCK = 8,
   parameter int T_XFER          = 16,
   parameter int T_ERASE         = 100,
   parameter int T_PROG          = 24,
   localparam int PAW     = $clog2(N_PAGES),
   localparam int BAW     = $clog2(PAGE_BYTES),
   localparam int BLK_LOG = $clog2(PAGES_PER_BLOCK),
   localparam int SW      = (BLK_LOG > 0) ? BLK_LOG : 1,
   localparam int TMAX    = (T_ERASE > T_PROG) ? ((T_ERASE > T_XFER) ? T_ERASE : T_XFER)
                                               : ((T_PROG > T_XFER) ? T_PROG : T_XFER),
   localparam int CW      = $clog2(TMAX + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  op_e            op_i,
   input  logic [PAW-1:0] page_i,
   input  logic           sel_i,
   output logic           busy_o,
   output logic           err_o,
   output logic           act_sel_o,
   output logic           arr_we_o,
   output logic [PAW-1:0] arr_wpage_o,
   output logic [BAW-1:0] arr_wbyte_o,
   output logic [7:0]     arr_wdata_o,
   output logic [PAW-1:0] arr_rpage_o,
   output logic [BAW-1:0] arr_rbyte_o,
   input  logic [7:0]     arr_rdata_i,
   output logic           buf_we_o,
   output logic [BAW-1:0] buf_addr_o,
   output logic [7:0]     buf_wdata_o,
   input  logic [7:0]     buf_rdata_i
);
   phase_e         phase_q, nxt;
   op_e            op_q;
   logic [PAW-1:0] page_q, blk_page, erase_page;
   logic           sel_q, err_q;
   logic [BAW-1:0] idx_q;
   logic [SW-1:0]  sub_q;
   logic           walk_done_q, act;
   logic           tmr_load, tmr_zero;
   logic [CW-1:0]  tmr_val;

   function automatic phase_e first_ph(input op_e o);
      return (o == OP_REWRITE) ? PH_XFER : PH_ERASE;
   endfunction

   function automatic phase_e after_ph(input phase_e p, input op_e o);
      case (p)
         PH_XFER:  return PH_ERASE;
         PH_ERASE: return (o == OP_PROGRAM || o == OP_REWRITE) ? PH_PROG : PH_IDLE;
         default:  return PH_IDLE;
      endcase
   endfunction

   function automatic logic [CW-1:0] ph_len_m1(input phase_e p);
      case (p)
         PH_XFER:  return CW'(T_XFER - 1);
         PH_ERASE: return CW'(T_ERASE - 1);
         PH_PROG:  return CW'(T_PROG - 1);
         default:  return '0;
      endcase
   endfunction

   always_comb begin
      nxt = phase_q;
      if (phase_q == PH_IDLE) begin
         if (start_i) nxt = first_ph(op_i);
      end else if (tmr_zero) begin
         nxt = after_ph(phase_q, op_q);
      end
   end

   assign tmr_load = (nxt != phase_q) && (nxt != PH_IDLE);
   assign tmr_val  = ph_len_m1(nxt);

   fps_phase_timer #(.CW(CW)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (tmr_load),
      .load_val_i(tmr_val),
      .run_i     (phase_q != PH_IDLE),
      .zero_o    (tmr_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         op_q    <= OP_PROGRAM;
         page_q  <= '0;
         sel_q   <= 1'b0;
      end else begin
         phase_q <= nxt;
         if (phase_q == PH_IDLE && start_i) begin
            op_q   <= op_i;
            page_q <= page_i;
            sel_q  <= sel_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            err_q <= 1'b0;
      else if (start_i && phase_q != PH_IDLE) err_q <= 1'b1;
   end

   // byte walk: one byte per cycle from the start of every phase window
   assign act = (phase_q != PH_IDLE) && !walk_done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q       <= '0;
         sub_q       <= '0;
         walk_done_q <= 1'b0;
      end else if (nxt != phase_q) begin
         idx_q       <= '0;
         sub_q       <= '0;
         walk_done_q <= 1'b0;
      end else if (act) begin
         if (idx_q == BAW'(PAGE_BYTES - 1)) begin
            idx_q <= '0;
            if (phase_q == PH_ERASE && op_q == OP_BLK_ERASE &&
                sub_q != SW'(PAGES_PER_BLOCK - 1))
               sub_q <= sub_q + 1'b1;
            else
               walk_done_q <= 1'b1;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   generate
      if (BLK_LOG > 0) begin : g_blk
         assign blk_page = {page_q[PAW-1:BLK_LOG], sub_q};
      end else begin : g_noblk
         assign blk_page = page_q;
      end
   endgenerate

   assign erase_page  = (op_q == OP_BLK_ERASE) ? blk_page : page_q;

   assign arr_we_o    = act && (phase_q == PH_ERASE || phase_q == PH_PROG);
   assign arr_wpage_o = (phase_q == PH_ERASE) ? erase_page : page_q;
   assign arr_wbyte_o = idx_q;
   assign arr_wdata_o = (phase_q == PH_ERASE) ? ERASED_BYTE : buf_rdata_i;
   assign arr_rpage_o = page_q;
   assign arr_rbyte_o = idx_q;
   assign buf_we_o    = act && (phase_q == PH_XFER);
   assign buf_addr_o  = idx_q;
   assign buf_wdata_o = arr_rdata_i;

   assign busy_o    = (phase_q != PH_IDLE);
   assign err_o     = err_q;
   assign act_sel_o = sel_q;

   // R7
   ph_adv_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(phase_q) != PH_IDLE && phase_q != $past(phase_q)) |-> $past(tmr_zero));

   // R3
   prog_after_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_PROG && $past(phase_q) != PH_PROG) |-> $past(phase_q) == PH_ERASE);

   // R4
   xfer_then_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(phase_q) == PH_XFER && phase_q != PH_XFER) |-> phase_q == PH_ERASE);

   // R8
   busy_start_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_o) |=> err_o);

   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);

   // R8
   target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> ($stable(page_q) && $stable(sel_q) && $stable(op_q)));
endmodule

// File: rtl/flash_page_seq.sv
module flash_page_seq
   import fps_pkg::*;
#(
   parameter int N_PAGES         = 32,
   parameter int PAGE_BYTES      = 12,
   parameter int PAGES_PER_BLOCK = 8,
   parameter int T_XFER          = 16,
   parameter int T_ERASE         = 100,
   parameter int T_PROG          = 24,
   localparam int PAW = $clog2(N_PAGES),
   localparam int BAW = $clog2(PAGE_BYTES)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic [1:0]     cmd_i,
   input  logic [PAW-1:0] page_i,
   input  logic           bufsel_i,
   output logic           busy_o,
   output logic           ready_o,
   output logic           err_o,
   input  logic           hw_en_i,
   input  logic           hw_sel_i,
   input  logic [BAW-1:0] hw_addr_i,
   input  logic [7:0]     hw_data_i,
   input  logic           hr_sel_i,
   input  logic [BAW-1:0] hr_addr_i,
   output logic [7:0]     hr_data_o,
   input  logic [PAW-1:0] ar_page_i,
   input  logic [BAW-1:0] ar_byte_i,
   output logic [7:0]     ar_data_o
);
   generate
      if (PAGE_BYTES < 2)                         begin : g_e0 $error("PAGE_BYTES too small"); end
      if ((1 << PAW) != N_PAGES)                  begin : g_e1 $error("N_PAGES must be a power of two"); end
      if ((1 << $clog2(PAGES_PER_BLOCK)) != PAGES_PER_BLOCK || PAGES_PER_BLOCK > N_PAGES)
                                                  begin : g_e2 $error("bad PAGES_PER_BLOCK"); end
      if (T_XFER < PAGE_BYTES)                    begin : g_e3 $error("T_XFER shorter than a page walk"); end
      if (T_PROG < PAGE_BYTES)                    begin : g_e4 $error("T_PROG shorter than a page walk"); end
      if (T_ERASE < PAGE_BYTES * PAGES_PER_BLOCK) begin : g_e5 $error("T_ERASE shorter than a block walk"); end
   endgenerate

   logic           busy, act_sel;
   logic           a_we, s_buf_we;
   logic [PAW-1:0] a_wpage, a_rpage;
   logic [BAW-1:0] a_wbyte, a_rbyte, s_buf_addr;
   logic [7:0]     a_wdata, a_rdata, s_buf_wdata, s_buf_rdata;
   logic [7:0]     b_seq_rd  [N_BUFS];
   logic [7:0]     b_host_rd [N_BUFS];

   fps_sequencer #(
      .N_PAGES(N_PAGES), .PAGE_BYTES(PAGE_BYTES), .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
      .T_XFER(T_XFER), .T_ERASE(T_ERASE), .T_PROG(T_PROG)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .op_i       (op_e'(cmd_i)),
      .page_i     (page_i),
      .sel_i      (bufsel_i),
      .busy_o     (busy),
      .err_o      (err_o),
      .act_sel_o  (act_sel),
      .arr_we_o   (a_we),
      .arr_wpage_o(a_wpage),
      .arr_wbyte_o(a_wbyte),
      .arr_wdata_o(a_wdata),
      .arr_rpage_o(a_rpage),
      .arr_rbyte_o(a_rbyte),
      .arr_rdata_i(a_rdata),
      .buf_we_o   (s_buf_we),
      .buf_addr_o (s_buf_addr),
      .buf_wdata_o(s_buf_wdata),
      .buf_rdata_i(s_buf_rdata)
   );

   fps_flash_array #(.N_PAGES(N_PAGES), .PAGE_BYTES(PAGE_BYTES)) u_arr (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (a_we),
      .wpage_i  (a_wpage),
      .wbyte_i  (a_wbyte),
      .wdata_i  (a_wdata),
      .rpage_a_i(a_rpage),
      .rbyte_a_i(a_rbyte),
      .rdata_a_o(a_rdata),
      .rpage_b_i(ar_page_i),
      .rbyte_b_i(ar_byte_i),
      .rdata_b_o(ar_data_o)
   );

   for (genvar b = 0; b < N_BUFS; b++) begin : g_buf
      logic           seq_we, host_we, we;
      logic [BAW-1:0] waddr;
      logic [7:0]     wdata;

      assign seq_we  = s_buf_we && (act_sel == b[0]);
      assign host_we = hw_en_i && (hw_sel_i == b[0]) && !(busy && act_sel == b[0]);
      assign we      = seq_we || host_we;
      assign waddr   = seq_we ? s_buf_addr  : hw_addr_i;
      assign wdata   = seq_we ? s_buf_wdata : hw_data_i;

      fps_page_buffer #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
         .clk      (clk),
         .we_i     (we),
         .waddr_i  (waddr),
         .wdata_i  (wdata),
         .raddr_a_i(a_rbyte),
         .rdata_a_o(b_seq_rd[b]),
         .raddr_b_i(hr_addr_i),
         .rdata_b_o(b_host_rd[b])
      );

      // R9
      host_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (seq_we && hw_en_i && hw_sel_i == b[0]) |-> !host_we);
   end

   assign s_buf_rdata = b_seq_rd[act_sel];
   assign hr_data_o   = b_host_rd[hr_sel_i];
   assign busy_o      = busy;
   assign ready_o     = !busy;
endmodule

// File: tb/flash_page_seq_tb.sv
`timescale 1ns/100ps
module flash_page_seq_tb;
   localparam int N_PAGES = 32, PB = 12, PPB = 8;
   localparam int T_X = 16, T_E = 100, T_P = 24;
   localparam int PAW = $clog2(N_PAGES), BAW = $clog2(PB);

   logic clk = 1'b0, rst_n = 1'b0;
   logic start_i = 0, bufsel_i = 0, hw_en_i = 0, hw_sel_i = 0, hr_sel_i = 0;
   logic [1:0] cmd_i = 0;
   logic [PAW-1:0] page_i = 0, ar_page_i = 0;
   logic [BAW-1:0] hw_addr_i = 0, hr_addr_i = 0, ar_byte_i = 0;
   logic [7:0] hw_data_i = 0;
   logic busy_o, ready_o, err_o;
   logic [7:0] hr_data_o, ar_data_o;

   always #10 clk = ~clk;

   flash_page_seq u_dut (.*);

   logic [7:0] m_arr [N_PAGES][PB];
   logic [7:0] m_buf [2][PB];
   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int dur(input int c);
      case (c)
         0: return T_E + T_P;
         1: return T_X + T_E + T_P;
         default: return T_E;
      endcase
   endfunction

   task automatic model_apply(input int c, input int p, input int s);
      case (c)
         0: for (int i = 0; i < PB; i++) m_arr[p][i] = m_buf[s][i];
         1: for (int i = 0; i < PB; i++) m_buf[s][i] = m_arr[p][i];
         2: for (int i = 0; i < PB; i++) m_arr[p][i] = 8'hFF;
         default: begin
            int base = p & ~(PPB - 1);
            for (int q = 0; q < PPB; q++)
               for (int i = 0; i < PB; i++) m_arr[base+q][i] = 8'hFF;
         end
      endcase
   endtask

   task automatic cmp_array(input string req);
      int bad = 0, got = 0, exp = 0;
      for (int p = 0; p < N_PAGES; p++)
         for (int i = 0; i < PB; i++) begin
            ar_page_i = PAW'(p); ar_byte_i = BAW'(i); #1;
            if (ar_data_o !== m_arr[p][i]) begin
               if (bad == 0) begin got = ar_data_o; exp = m_arr[p][i]; end
               bad++;
            end
         end
      chk(bad == 0, req, "array content (first bad byte)", got, exp);
   endtask

   task automatic cmp_buf(input int s, input string req);
      int bad = 0, got = 0, exp = 0;
      hr_sel_i = s[0];
      for (int i = 0; i < PB; i++) begin
         hr_addr_i = BAW'(i); #1;
         if (hr_data_o !== m_buf[s][i]) begin
            if (bad == 0) begin got = hr_data_o; exp = m_buf[s][i]; end
            bad++;
         end
      end
      chk(bad == 0, req, $sformatf("buffer %0d content", s), got, exp);
   endtask

   task automatic fill_buf(input int s);
      for (int i = 0; i < PB; i++) begin
         @(negedge clk);
         hw_en_i = 1; hw_sel_i = s[0]; hw_addr_i = BAW'(i); hw_data_i = 8'($urandom);
         m_buf[s][i] = hw_data_i;
      end
      @(negedge clk); hw_en_i = 0;
   endtask

   // mode: 0 plain, 1 erase-window sample, 2 start while busy, 3 host writes while busy
   task automatic run_cmd(input int c, input int p, input int s, input int mode, input string req);
      int cyc = 0;
      @(negedge clk);
      start_i = 1; cmd_i = 2'(c); page_i = PAW'(p); bufsel_i = s[0];
      @(negedge clk);
      start_i = 0;
      while (busy_o && cyc < 1000) begin
         cyc++;
         if (ready_o !== 1'b0) chk(0, "R7", "ready while busy", ready_o, 0);
         if (mode == 1 && cyc == T_E + 1) begin
            ar_page_i = PAW'(p);
            ar_byte_i = BAW'(PB - 1); #1;
            chk(ar_data_o == 8'hFF, "R3", "last byte after erase window", ar_data_o, 8'hFF);
            ar_byte_i = '0; #1;
            chk(ar_data_o == 8'hFF, "R3", "first byte before program", ar_data_o, 8'hFF);
         end
         if (mode == 2 && cyc == 3) begin
            start_i = 1; cmd_i = 2'd3; page_i = PAW'(p ^ PPB);
         end
         if (mode == 2 && cyc == 4) start_i = 0;
         if (mode == 3 && cyc == 5) begin
            hw_en_i = 1; hw_sel_i = s[0]; hw_addr_i = BAW'(2); hw_data_i = ~m_buf[s][2];
         end
         if (mode == 3 && cyc == 6) begin
            hw_sel_i = ~s[0]; hw_addr_i = BAW'(3); hw_data_i = 8'h5A;
            m_buf[1-s][3] = 8'h5A;
         end
         if (mode == 3 && cyc == 7) hw_en_i = 0;
         @(negedge clk);
      end
      chk(cyc == dur(c), req, $sformatf("busy cycles for op %0d", c), cyc, dur(c));
      chk(ready_o == 1'b1, "R7", "ready after sequence", ready_o, 1);
      model_apply(c, p, s);
   endtask

   initial begin
      void'($urandom(32'h00C0FFEE));
      repeat (3) @(negedge clk);
      chk(busy_o == 0 && ready_o == 1 && err_o == 0, "R1", "status in reset",
          {busy_o, ready_o, err_o}, 3'b010);
      rst_n = 1;
      @(negedge clk);
      chk(busy_o == 0 && ready_o == 1 && err_o == 0, "R1", "status after reset",
          {busy_o, ready_o, err_o}, 3'b010);

      // R6: bring array to a known state, random low page bits
      for (int b = 0; b < N_PAGES / PPB; b++)
         run_cmd(3, b * PPB + int'($urandom_range(PPB - 1)), 0, 0, "R6");
      cmp_array("R6");

      // R2 then R3: reprogram a page holding data
      fill_buf(0);
      run_cmd(0, 5, 0, 0, "R2");
      cmp_array("R2");
      fill_buf(0);
      run_cmd(0, 5, 0, 1, "R3");
      cmp_array("R3");

      // R4 / R10: rewrite restores buffer from page, other buffer untouched
      fill_buf(1);
      run_cmd(0, 9, 1, 0, "R2");
      fill_buf(1);
      run_cmd(1, 9, 1, 0, "R4");
      cmp_buf(1, "R4");
      cmp_buf(0, "R10");
      cmp_array("R4");

      // R5 page erase, neighbours kept
      run_cmd(2, 9, 0, 0, "R5");
      cmp_array("R5");

      // R6 block erase with nonzero low bits
      fill_buf(0);
      run_cmd(0, 17, 0, 0, "R2");
      run_cmd(0, 22, 0, 0, "R2");
      run_cmd(0, 25, 0, 0, "R2");
      run_cmd(3, 19, 0, 0, "R6");
      cmp_array("R6");

      // R8 start while busy
      fill_buf(1);
      run_cmd(0, 3, 1, 2, "R8");
      chk(err_o == 1, "R8", "error flag after busy start", err_o, 1);
      cmp_array("R8");

      // R9 host writes while busy
      run_cmd(0, 12, 0, 3, "R9");
      cmp_buf(0, "R9");
      cmp_buf(1, "R9");
      cmp_array("R9");
      chk(err_o == 1, "R8", "error flag sticky", err_o, 1);

      // R1 abort during transfer
      @(negedge clk);
      start_i = 1; cmd_i = 2'd1; page_i = PAW'(5); bufsel_i = 1;
      @(negedge clk); start_i = 0;
      repeat (10) @(negedge clk);
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(busy_o == 0 && ready_o == 1 && err_o == 0, "R1", "status after abort",
          {busy_o, ready_o, err_o}, 3'b010);
      repeat (150) @(negedge clk);
      chk(busy_o == 0, "R1", "no resume after abort", busy_o, 0);
      cmp_array("R1");
      fill_buf(1);

      // random mix
      for (int it = 0; it < 16; it++) begin
         int c = int'($urandom_range(3));
         int p = int'($urandom_range(N_PAGES - 1));
         int s = int'($urandom_range(1));
         string rq;
         if ($urandom_range(1) == 1) fill_buf(s);
         rq = (c == 0) ? "R2" : (c == 1) ? "R4" : (c == 2) ? "R5" : "R6";
         run_cmd(c, p, s, 0, rq);
         cmp_array(rq);
         cmp_buf(s, rq);
         cmp_buf(1 - s, "R10");
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not complete, got 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule